// File: doc/BRIEF.md
# Manchester Line Receiver with Drift Tracking

This block turns a Manchester-coded serial line back into data bits. A tick at sixteen times the bit rate paces a period counter. Each bit period normally lasts sixteen ticks, and the mid-bit transition is expected at count 8. Before a frame the line sits still. The first transition the block sees is taken as the mid-bit edge of a one-bit start delimiter. That delimiter carries no data, and the data bits follow it directly. Each data bit is decoded from the direction of its mid-bit transition and handed out with a one-cycle strobe.

When drift tracking is on, the block measures where each data transition lands against count 8. If the transition is early by two to four ticks, the block trims the current period to fifteen ticks. If it is late by two or three ticks, the block stretches the current period to seventeen ticks. This lets the receiver follow a transmitter whose clock runs slightly fast or slow. A transition within one tick of count 8 is treated as jitter, and the period stays at sixteen ticks. If no transition arrives in the acceptance window, the block raises a sync error and goes back to looking for a delimiter. Tracking is only built in when the oversampling parameter is 16. For any other oversampling value it is tied off, whatever the enable input says.

Top module: `manchester_rx`

## Requirements
- R1: While reset is held, and on the first cycle after reset, `bit_vld` and `sync_err` are low.
- R2: With `pol_inv`=0, a high-to-low mid-bit transition decodes as 1 and a low-to-high one as 0. `bit_vld` pulses for one clock on the clock after the tick that samples the transition.
- R3: With `pol_inv`=1, the mapping of R2 is inverted: a high-to-low transition decodes as 0 and a low-to-high one as 1.
- R4: From idle, the first transition is a start delimiter and yields no bit. Data bits follow at once, one `bit_vld` each. Transitions outside the window, such as those at bit boundaries, are ignored.
- R5: With `drift_en`=0, every bit period is exactly 16 ticks. A transmitter that is one tick per bit slow therefore fails on its fourth data bit, and one that is one tick per bit fast fails on its fifth.
- R6: A data transition within one tick of count 8, early or late, leaves the period at 16 ticks.
- R7: With `drift_en`=1, a data transition 2 or 3 ticks late makes that bit period 17 ticks.
- R8: With `drift_en`=1, a data transition 2 to 4 ticks early makes that bit period 15 ticks.
- R9: If a data bit has no transition from 4 ticks early to 3 ticks late, `sync_err` pulses for one clock. The block then returns to idle, and the next transition starts a new delimiter.
- R10: After NBITS data bits the block returns to idle by itself, and the next transition is taken as a new delimiter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling tick, one clock wide, at OSR times the bit rate |
| line_in | input | 1 | Manchester-coded serial line |
| drift_en | input | 1 | Enables drift tracking (only effective when OSR is 16) |
| pol_inv | input | 1 | Inverts the edge-to-bit mapping |
| bit_o | output | 1 | Recovered data bit, valid with bit_vld |
| bit_vld | output | 1 | One-clock strobe per recovered data bit |
| sync_err | output | 1 | One-clock strobe when the expected mid-bit transition is missing |

## Verification
The bench builds the receiver with OSR=16, so drift tracking is actually present, and with NBITS=5. Five bits are enough for a transmitter running one tick slow or fast per bit to step through every offset class, from jitter through correction to loss of lock. Frames are placed with explicit per-bit edge times. This puts single transitions exactly on the -4, -5, +3 and +4 window borders. It also builds sequences in which a wrongly applied correction at ±1 would push the next edge out of the window.

// File: rtl/mrx_pkg.sv
`timescale 1ns/1ps
package mrx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_DELIM = 2'd1,
        RX_DATA  = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        TRIM_NONE  = 2'd0,
        TRIM_SHORT = 2'd1,
        TRIM_LONG  = 2'd2
    } trim_e;

    typedef struct packed {
        logic seen;
        logic rising;
    } edge_s;

    typedef struct packed {
        logic vld;
        logic bit_val;
        logic err;
    } rx_out_s;

    localparam int EARLY_TOL = 4;
    localparam int LATE_TOL  = 3;
    localparam int JITTER    = 1;

    // Maps the signed distance of a transition from the expected edge to a trim.
    function automatic trim_e classify_offset(input int off);
        if (off >= -EARLY_TOL && off <= -(JITTER + 1))
            return TRIM_SHORT;
        else if (off >= (JITTER + 1) && off <= LATE_TOL)
            return TRIM_LONG;
        else
            return TRIM_NONE;
    endfunction

endpackage

// File: rtl/mrx_edge_det.sv
`timescale 1ns/1ps
module mrx_edge_det
    import mrx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  line_in,
    output edge_s ev
);
    logic line_q;

    always_ff @(posedge clk) begin
        if (rst)
            line_q <= line_in;
        else if (tick)
            line_q <= line_in;
    end

    assign ev.seen   = tick && (line_in != line_q);
    assign ev.rising = line_in;

endmodule

// File: rtl/mrx_period_timer.sv
`timescale 1ns/1ps
module mrx_period_timer
    import mrx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int CW  = $clog2(OSR + 2)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          run,
    input  logic          start,
    input  trim_e         trim,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    localparam logic [CW-1:0] NOM_LAST  = CW'(OSR - 1);
    localparam logic [CW-1:0] LOAD_VAL  = CW'(OSR / 2 + 1);

    logic [CW-1:0] last_q;

    assign wrap = tick && run && (cnt == last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            last_q <= NOM_LAST;
        end else if (tick) begin
            if (start) begin
                cnt    <= LOAD_VAL;
                last_q <= NOM_LAST;
            end else if (!run || cnt == last_q) begin
                cnt    <= '0;
                last_q <= NOM_LAST;
            end else begin
                cnt <= cnt + 1'b1;
                case (trim)
                    TRIM_SHORT: last_q <= NOM_LAST - 1'b1;
                    TRIM_LONG:  last_q <= NOM_LAST + 1'b1;
                    default:    last_q <= last_q;
                endcase
            end
        end
    end

endmodule

// File: rtl/mrx_ctrl.sv
`timescale 1ns/1ps
module mrx_ctrl
    import mrx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int NBITS = 8,
    parameter int CW    = $clog2(OSR + 2)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  edge_s         ev,
    input  logic [CW-1:0] cnt,
    input  logic          wrap,
    input  logic          drift_en,
    input  logic          pol_inv,
    output rx_state_e     state,
    output logic          start,
    output trim_e         trim,
    output rx_out_s       out
);
    localparam int MID    = OSR / 2;
    localparam int WIN_LO = MID - EARLY_TOL;
    localparam int WIN_HI = MID + LATE_TOL;
    localparam int BW     = $clog2(NBITS + 1);

    logic          seen_q;
    logic [BW-1:0] nb_q;
    logic          comp_on;
    logic          in_win;
    logic          take;
    logic          miss;

    generate
        if (OSR == 16) begin : g_track
            assign comp_on = drift_en;
        end else begin : g_no_track
            assign comp_on = 1'b0;
        end
    endgenerate

    assign in_win = (int'(cnt) >= WIN_LO) && (int'(cnt) <= WIN_HI);
    assign start  = tick && (state == RX_IDLE) && ev.seen;
    assign take   = tick && (state == RX_DATA) && ev.seen && in_win && !seen_q;
    assign miss   = tick && (state == RX_DATA) && !seen_q && !take
                    && (int'(cnt) == WIN_HI);
    assign trim   = (take && comp_on) ? classify_offset(int'(cnt) - MID) : TRIM_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            seen_q <= 1'b0;
            nb_q   <= '0;
            out    <= '0;
        end else begin
            out.vld <= 1'b0;
            out.err <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (start) state <= RX_DELIM;
                end
                RX_DELIM: begin
                    if (wrap) begin
                        state  <= RX_DATA;
                        seen_q <= 1'b0;
                        nb_q   <= '0;
                    end
                end
                RX_DATA: begin
                    if (take) begin
                        seen_q      <= 1'b1;
                        nb_q        <= nb_q + 1'b1;
                        out.vld     <= 1'b1;
                        out.bit_val <= ~ev.rising ^ pol_inv;
                    end else if (miss) begin
                        out.err <= 1'b1;
                        state   <= RX_IDLE;
                    end
                    if (wrap) begin
                        seen_q <= 1'b0;
                        if (nb_q == BW'(NBITS)) state <= RX_IDLE;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/manchester_rx.sv
`timescale 1ns/1ps
module manchester_rx
    import mrx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int NBITS = 8
)(
    input  logic clk,
    input  logic rst,
    input  logic os_tick,
    input  logic line_in,
    input  logic drift_en,
    input  logic pol_inv,
    output logic bit_o,
    output logic bit_vld,
    output logic sync_err
);
    localparam int CW = $clog2(OSR + 2);

    edge_s         ev_w;
    rx_state_e     state_w;
    logic          start_w;
    trim_e         trim_w;
    logic [CW-1:0] cnt_w;
    logic          wrap_w;
    rx_out_s       out_w;

    mrx_edge_det u_edge (
        .clk     (clk),
        .rst     (rst),
        .tick    (os_tick),
        .line_in (line_in),
        .ev      (ev_w)
    );

    mrx_period_timer #(.OSR(OSR), .CW(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .tick  (os_tick),
        .run   (state_w != RX_IDLE),
        .start (start_w),
        .trim  (trim_w),
        .cnt   (cnt_w),
        .wrap  (wrap_w)
    );

    mrx_ctrl #(.OSR(OSR), .NBITS(NBITS), .CW(CW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .tick     (os_tick),
        .ev       (ev_w),
        .cnt      (cnt_w),
        .wrap     (wrap_w),
        .drift_en (drift_en),
        .pol_inv  (pol_inv),
        .state    (state_w),
        .start    (start_w),
        .trim     (trim_w),
        .out      (out_w)
    );

    assign bit_o    = out_w.bit_val;
    assign bit_vld  = out_w.vld;
    assign sync_err = out_w.err;

endmodule

// File: rtl/mrx_checker.sv
`timescale 1ns/1ps
module mrx_checker
    import mrx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int CW  = $clog2(OSR + 2)
)(
    input logic          clk,
    input logic          rst,
    input logic          bit_vld,
    input logic          sync_err,
    input rx_state_e     state,
    input logic [CW-1:0] cnt,
    input logic          wrap
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bit_vld && !sync_err)); // R1

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bit_vld |=> !bit_vld); // R4

    AST_VLD_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        bit_vld |-> (state == RX_DATA)); // R4

    AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> (state == RX_IDLE)); // R9

    AST_ERR_NOT_WITH_BIT: assert property (@(posedge clk) disable iff (rst)
        !(sync_err && bit_vld)); // R9

    AST_PERIOD_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        (wrap && state == RX_DATA) |-> (int'(cnt) >= OSR - 2 && int'(cnt) <= OSR)); // R7

endmodule

bind manchester_rx mrx_checker #(.OSR(OSR), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_vld  (bit_vld),
    .sync_err (sync_err),
    .state    (state_w),
    .cnt      (cnt_w),
    .wrap     (wrap_w)
);

// File: tb/tb_manchester_rx.sv
`timescale 1ns/1ps
module tb_manchester_rx;
    localparam int NB  = 5;
    localparam int OSR = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic os_tick = 1'b0;
    logic line_in = 1'b1;
    logic drift_en = 1'b1;
    logic pol_inv = 1'b0;
    logic bit_o, bit_vld, sync_err;

    int checks = 0;
    int bad = 0;
    int err_seen = 0;
    int tnow = 0;
    int phase = 0;
    int exp_q[$];
    string cur_req = "R1";
    bit done = 1'b0;

    manchester_rx #(.OSR(OSR), .NBITS(NB)) dut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .line_in(line_in),
        .drift_en(drift_en), .pol_inv(pol_inv),
        .bit_o(bit_o), .bit_vld(bit_vld), .sync_err(sync_err)
    );

    always #2.5 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            phase   = (phase + 1) % 4;
            os_tick = (phase == 0);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        bad++;
        $display("FAIL watchdog (%s): got running expected finished", cur_req);
        finish_run();
    end

    // Scoreboard, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (bit_vld) begin
                checks++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL %s (R4) stray bit: got bit_vld=1 expected 0", cur_req);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (int'(bit_o) != e) begin
                        bad++;
                        $display("FAIL %s bit value: got %0d expected %0d", cur_req, bit_o, e);
                    end
                end
            end
            if (sync_err) err_seen++;
        end
    end

    task automatic wait_tick();
        @(posedge clk);
        while (!os_tick) @(posedge clk);
        #1;
        tnow++;
    endtask

    // Behavioural prediction from edge times (ticks after the delimiter edge)
    task automatic predict(input int et[NB], input int nsend, input bit comp,
                           output int nok, output int nerr);
        int rx_start;
        int off;
        rx_start = OSR / 2;
        nok = 0;
        nerr = 0;
        for (int k = 0; k < NB; k++) begin
            if (k >= nsend) begin
                nerr = 1;
                return;
            end
            off = et[k] - (rx_start + OSR / 2);
            if (off < -4) begin
                nerr = 1;
                return;
            end
            if (off > 3) begin
                nerr = 2;
                return;
            end
            nok++;
            if (comp && off <= -2)     rx_start += OSR - 1;
            else if (comp && off >= 2) rx_start += OSR + 1;
            else                       rx_start += OSR;
        end
    endtask

    task automatic run_frame(input string req, input bit comp, input bit pol,
                             input int et[NB], input bit d[NB], input int nsend);
        int nok, nerr, prev_e, bnd;
        logic lvb;
        cur_req  = req;
        drift_en = comp;
        pol_inv  = pol;
        predict(et, nsend, comp, nok, nerr);
        for (int k = 0; k < nok; k++) exp_q.push_back(int'(d[k]));
        err_seen = 0;
        wait_tick();
        line_in = ~line_in;
        tnow = 0;
        prev_e = 0;
        for (int k = 0; k < nsend; k++) begin
            lvb = d[k] ^ pol;
            if (line_in != lvb) begin
                bnd = (prev_e + et[k]) / 2;
                while (tnow < bnd) wait_tick();
                line_in = lvb;
            end
            while (tnow < et[k]) wait_tick();
            line_in = ~lvb;
            prev_e = et[k];
        end
        repeat (70) wait_tick();
        checks++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL %s bit count: got %0d missing expected 0 missing", req, exp_q.size());
            exp_q.delete();
        end
        checks++;
        if (err_seen != nerr) begin
            bad++;
            $display("FAIL %s sync errors: got %0d expected %0d", req, err_seen, nerr);
        end
    endtask

    function automatic void fill_period(output int et[NB], input int p);
        for (int k = 0; k < NB; k++) et[k] = p * (k + 1);
    endfunction

    initial begin
        int et[NB];
        bit d_a[NB];
        bit d_b[NB];
        bit d_alt[NB];
        d_a   = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
        d_b   = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
        d_alt = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

        repeat (5) @(posedge clk);
        #1;
        checks++;
        if (bit_vld !== 1'b0 || sync_err !== 1'b0) begin
            bad++;
            $display("FAIL R1 in reset: got vld=%0b err=%0b expected 0 0", bit_vld, sync_err);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (bit_vld !== 1'b0 || sync_err !== 1'b0) begin
            bad++;
            $display("FAIL R1 after reset: got vld=%0b err=%0b expected 0 0", bit_vld, sync_err);
        end
        repeat (4) wait_tick();

        fill_period(et, 16);
        run_frame("R2 R4 nominal", 1'b1, 1'b0, et, d_a, NB);
        run_frame("R3 R10 inverted", 1'b1, 1'b1, et, d_b, NB);
        run_frame("R2 R10 second", 1'b0, 1'b0, et, d_b, NB);

        fill_period(et, 17);
        run_frame("R7 slow tracked", 1'b1, 1'b0, et, d_b, NB);
        run_frame("R5 R9 slow fixed", 1'b0, 1'b0, et, d_alt, 4);

        fill_period(et, 15);
        run_frame("R8 fast tracked", 1'b1, 1'b0, et, d_a, NB);
        run_frame("R5 fast fixed", 1'b0, 1'b0, et, d_alt, NB);

        et = '{17, 28, 47, 63, 79};
        run_frame("R6 R8 late jitter", 1'b1, 1'b0, et, d_alt, NB);
        et = '{15, 35, 49, 65, 81};
        run_frame("R6 R7 early jitter", 1'b1, 1'b1, et, d_alt, NB);

        fill_period(et, 11);
        run_frame("R9 too early", 1'b1, 1'b0, et, d_alt, 1);
        fill_period(et, 16);
        run_frame("R9 no edge", 1'b1, 1'b0, et, d_alt, 0);
        run_frame("R9 R10 recover", 1'b1, 1'b0, et, d_a, NB);

        finish_run();
    end

endmodule